// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a processor's load/store stage and a 32-bit, word-wide data memory that is addressed by byte. For a store, the core supplies the effective address, the source-register data and a width code. The block returns four things: a word-aligned memory address, one write strobe per byte lane, the source data moved onto the lanes the address selects, and a flag that marks a misaligned request.

For a load, the memory is taken to answer one cycle after the request. The block keeps the byte offset and width code of each load it issues. When the memory word comes back, it moves the selected byte or halfword down to bit 0 and extends it to 32 bits, with sign or zero fill, for the destination register.

Byte order is little-endian. A misaligned halfword or word access is flagged, and it never reaches the memory; the block does not split it into two accesses. A load is issued whatever register it targets, so side effects of the access are kept even when the result is thrown away.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr_o` equals `req_addr_i` with bits 1:0 forced to zero, in the same cycle.
- R2: The width code is `req_code_i[1:0]`: 00 byte, 01 halfword, 10 or 11 word. While `mem_req_o` is 1, `mem_be_o` is 4'b0001 shifted left by `req_addr_i[1:0]` for a byte, 4'b0011 shifted left by twice `req_addr_i[1]` for a halfword, and 4'b1111 for a word. `mem_be_o` is 4'b0000 whenever `mem_req_o` is 0.
- R3: A valid halfword request with `req_addr_i[0]`=1, or a valid word request with `req_addr_i[1:0]`≠0, drives `misalign_o`=1 and `mem_req_o`=0 in the same cycle. It writes no memory byte and gives no `ld_valid_o` in the next cycle.
- R4: Store data is little-endian: byte k of `req_wdata_i` is placed at bits 8*(offset+k)+7 : 8*(offset+k) of `mem_wdata_o` for each byte the width covers. A word store passes the whole value unchanged. `mem_we_o` is 1 only for an accepted store.
- R5: `req_code_i[2]` (unsigned flag) has no effect on stores: the strobes, data and memory contents are the same as with bit 2 clear.
- R6: `ld_valid_o` is 1 in exactly the cycle after an accepted load (`mem_req_o`=1, `mem_we_o`=0). In that cycle `ld_data_o` is built from `mem_rdata_i`.
- R7: A word load returns `mem_rdata_i` unchanged.
- R8: A byte or halfword load with `req_code_i[2]`=0 moves the selected lane to bit 0 and copies its top bit into all upper bits.
- R9: A byte or halfword load with `req_code_i[2]`=1 moves the selected lane to bit 0 and fills the upper bits with zeros.
- R10: While `rst_n` is 0, and in the first cycle after it rises, `ld_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Effective byte address |
| req_code_i | input | 3 | [1:0] width, [2] unsigned load |
| req_wdata_i | input | 32 | Store source data |
| mem_req_o | output | 1 | Aligned access issued to memory |
| mem_we_o | output | 1 | Issued access is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Per-byte lane enables |
| mem_wdata_o | output | 32 | Lane-steered write data |
| misalign_o | output | 1 | Current request is misaligned |
| mem_rdata_i | input | 32 | Memory read word, one cycle after the load request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
The bench loads every width at every byte offset, from words whose bytes have their top bits set in some lanes and clear in others. A design that skipped the shift down to bit 0, or that picked the sign from the wrong bit, would return a wrong value for the upper lanes or mix up sign and zero fill. Byte and halfword stores at each offset are checked against a byte-array reference by reading the whole word back. A wrong strobe would corrupt or miss a neighbouring byte. Misaligned requests and unsigned-coded stores are checked through the strobes, through the absence of a load result and through memory contents that must not change; a design that let a misaligned access through, or that read bit 2 on stores, would alter memory or the strobes.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;

  // Lane mask for an access of the given size at the given byte offset.
  function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = 4'b0011 << (off & 2'b10);
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Alignment violation for the size at the offset.
  function automatic logic off_bad(size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: off_bad = 1'b0;
      SZ_HALF: off_bad = off[0];
      default: off_bad = |off;
    endcase
  endfunction

  // Move the low bytes of the source onto their lanes.
  function automatic logic [DATA_W-1:0] place_data(size_e sz, logic [OFF_W-1:0] off,
                                                   logic [DATA_W-1:0] d);
    case (sz)
      SZ_BYTE: place_data = {24'b0, d[7:0]}  << {off, 3'b000};
      SZ_HALF: place_data = {16'b0, d[15:0]} << {off, 3'b000};
      default: place_data = d;
    endcase
  endfunction

  // Shift the selected lane down to bit 0, then extend.
  function automatic logic [DATA_W-1:0] load_extend(size_e sz, logic uns, logic [OFF_W-1:0] off,
                                                    logic [DATA_W-1:0] word);
    logic [DATA_W-1:0] sh;
    sh = word >> {off, 3'b000};
    case (sz)
      SZ_BYTE: load_extend = uns ? {24'b0, sh[7:0]}  : {{24{sh[7]}}, sh[7:0]};
      SZ_HALF: load_extend = uns ? {16'b0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
      default: load_extend = word;
    endcase
  endfunction
endpackage

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  size_e             size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              issue_o,
  output logic              we_o,
  output logic              bad_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [OFF_W-1:0] off;
  logic             misfit;

  assign off     = addr_i[OFF_W-1:0];
  assign misfit  = off_bad(size_i, off);
  assign bad_o   = valid_i & misfit;
  assign issue_o = valid_i & ~misfit;
  assign we_o    = issue_o & store_i;
  assign addr_o  = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign be_o    = issue_o ? lane_mask(size_i, off) : '0;
  assign wdata_o = place_data(size_i, off, wdata_i);
endmodule

// File: rtl/lsa_load_track.sv
module lsa_load_track
  import lsa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [OFF_W-1:0] off_i,
  input  size_e            size_i,
  input  logic             uns_i,
  output logic             pend_o,
  output logic [OFF_W-1:0] off_o,
  output size_e            size_o,
  output logic             uns_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      off_o  <= '0;
      size_o <= SZ_WORD;
      uns_o  <= 1'b0;
    end else begin
      pend_o <= capture_i;
      if (capture_i) begin
        off_o  <= off_i;
        size_o <= size_i;
        uns_o  <= uns_i;
      end
    end
  end
endmodule

// File: rtl/lsa_load_extend.sv
module lsa_load_extend
  import lsa_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  size_e             size_i,
  input  logic              uns_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = load_extend(size_i, uns_i, off_i, word_i);
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_code_i,
  input  logic [31:0]       req_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  output logic              misalign_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              ld_valid_o,
  output logic [31:0]       ld_data_o
);
  size_e            req_size;
  logic             ld_issue;
  logic [OFF_W-1:0] pend_off;
  size_e            pend_size;
  logic             pend_uns;

  assign req_size = size_e'(req_code_i[1:0]);

  lsa_store_lane #(.ADDR_W(ADDR_W)) u_req (
    .valid_i (req_valid_i),
    .store_i (req_store_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size),
    .wdata_i (req_wdata_i),
    .issue_o (mem_req_o),
    .we_o    (mem_we_o),
    .bad_o   (misalign_o),
    .addr_o  (mem_addr_o),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  assign ld_issue = mem_req_o & ~req_store_i;

  lsa_load_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (ld_issue),
    .off_i     (req_addr_i[OFF_W-1:0]),
    .size_i    (req_size),
    .uns_i     (req_code_i[2]),
    .pend_o    (ld_valid_o),
    .off_o     (pend_off),
    .size_o    (pend_size),
    .uns_o     (pend_uns)
  );

  lsa_load_extend u_ext (
    .off_i  (pend_off),
    .size_i (pend_size),
    .uns_i  (pend_uns),
    .word_i (mem_rdata_i),
    .data_o (ld_data_o)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        req_code_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              misalign_o,
  input logic              ld_valid_o
);
  // R1
  addr_word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_o[1:0] == 2'b00);

  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && req_code_i[1:0] == 2'b00) |-> $countones(mem_be_o) == 1);

  // R2
  idle_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_o |-> mem_be_o == 4'b0000);

  // R3
  misalign_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (!mem_req_o && !mem_we_o));

  // R3
  misalign_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |=> !ld_valid_o);

  // R6
  load_result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> ld_valid_o);

  // R6
  result_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> $past(mem_req_o && !mem_we_o));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !ld_valid_o);
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_code_i (req_code_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .misalign_o (misalign_o),
  .ld_valid_o (ld_valid_o)
);

// File: tb/test_lsu_lane_align.sv
`timescale 1ns/1ps
module test_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [2:0]  req_code_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, ld_valid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] mem_words [0:3];
  logic [7:0]  ref_bytes [0:15];

  always #5 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_store_i(req_store_i),
    .req_addr_i(req_addr_i), .req_code_i(req_code_i), .req_wdata_i(req_wdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .misalign_o(misalign_o),
    .mem_rdata_i(mem_rdata_i), .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o)
  );

  // Memory model: writes by lane, read answer one cycle later.
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o)
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem_words[mem_addr_o[3:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem_words[mem_addr_o[3:2]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [2:0] code);
    return (code[1:0] == 2'b00) ? 1 : (code[1:0] == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [3:0] exp_be(input logic [31:0] a, input logic [2:0] code);
    logic [3:0] m = '0;
    int n = nbytes(code);
    int o = int'(a[1:0]);
    if (o % n != 0) return 4'b0000;
    for (int b = 0; b < 4; b++) m[b] = (b >= o) && (b < o + n);
    return m;
  endfunction

  task automatic drive(input bit st, input logic [31:0] a, input logic [2:0] code,
                       input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_store_i = st; req_addr_i = a;
    req_code_i = code; req_wdata_i = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic t_store(input logic [31:0] a, input logic [2:0] code, input logic [31:0] d,
                         input string tag);
    logic [3:0]  be = exp_be(a, code);
    logic [31:0] msk = '0, exp_w = '0;
    int o = int'(a[1:0]);
    drive(1'b1, a, code, d);
    for (int k = 0; k < 4; k++)
      if (be[k]) begin
        msk[8*k +: 8] = 8'hFF;
        exp_w[8*k +: 8] = d[8*(k-o) +: 8];
      end
    chk({tag, " R2 strobes"}, {28'b0, mem_be_o}, {28'b0, be});
    chk({tag, " R4 lane data"}, mem_wdata_o & msk, exp_w);
    chk({tag, " R4 write enable"}, {31'b0, mem_we_o}, {31'b0, (be != 0)});
    chk({tag, " R1 address"}, mem_addr_o, {a[31:2], 2'b00});
    chk({tag, " R3 flag"}, {31'b0, misalign_o}, {31'b0, (be == 0)});
    for (int k = 0; k < 4; k++)
      if (be[k]) ref_bytes[{a[3:2], 2'b00} + 4'(k)] = exp_w[8*k +: 8];
    @(posedge clk);
    idle();
  endtask

  task automatic t_load(input logic [31:0] a, input logic [2:0] code, input string tag);
    int n = nbytes(code);
    logic [31:0] exp_v = '0;
    logic mis;
    drive(1'b0, a, code, 32'h0);
    mis = (exp_be(a, code) == 4'b0000);
    chk({tag, " R2 load strobes"}, {28'b0, mem_be_o}, {28'b0, exp_be(a, code)});
    chk({tag, " R3 load flag"}, {31'b0, misalign_o}, {31'b0, mis});
    for (int k = 0; k < n; k++) exp_v[8*k +: 8] = ref_bytes[a[3:0] + 4'(k)];
    if (!code[2] && n < 4 && exp_v[8*n-1])
      for (int k = 8*n; k < 32; k++) exp_v[k] = 1'b1;
    @(posedge clk);
    #2;
    chk({tag, " R6 result valid"}, {31'b0, ld_valid_o}, {31'b0, !mis});
    if (!mis) begin
      if (n == 4)       chk({tag, " R7 word"}, ld_data_o, exp_v);
      else if (code[2]) chk({tag, " R9 zero-extend"}, ld_data_o, exp_v);
      else              chk({tag, " R8 sign-extend"}, ld_data_o, exp_v);
    end
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 chk("R10 valid in reset", {31'b0, ld_valid_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R10 valid after reset", {31'b0, ld_valid_o}, 32'h0);
    chk("R2 idle strobes", {28'b0, mem_be_o}, 32'h0);
  endtask

  task automatic t_fill();
    t_store(32'h0, 3'b010, 32'h8192A3F4, "fill w0");
    t_store(32'h4, 3'b010, 32'h7F00FF80, "fill w1");
    t_store(32'h8, 3'b010, 32'h0123C567, "fill w2");
    t_store(32'hC, 3'b010, 32'hE9D87A6B, "fill w3");
  endtask

  task automatic t_load_sweep();
    logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 4; o++)
        for (int c = 0; c < 5; c++)
          t_load(32'(4*w + o), codes[c], "sweep");
  endtask

  task automatic t_store_sweep();
    for (int o = 0; o < 4; o++) begin
      t_store(32'(4 + o), 3'b000, 32'hA5A5A500 | 32'(o), "byte store");
      t_load(32'h4, 3'b010, "byte store readback");
    end
    t_store(32'h8, 3'b001, 32'hFFFF1234, "half store lo");
    t_store(32'hA, 3'b001, 32'h0000BEEF, "half store hi");
    t_load(32'h8, 3'b010, "half store readback");
  endtask

  task automatic t_misaligned();
    t_store(32'h1, 3'b001, 32'h0000DEAD, "R3 half odd");
    t_store(32'h3, 3'b001, 32'h0000DEAD, "R3 half top");
    t_store(32'h2, 3'b010, 32'hCAFEBABE, "R3 word off2");
    t_store(32'hD, 3'b011, 32'hCAFEBABE, "R3 word off1");
    t_load(32'h0, 3'b010, "R3 memory untouched w0");
    t_load(32'hC, 3'b010, "R3 memory untouched w3");
    t_load(32'h5, 3'b101, "R3 load half odd");
    t_load(32'h7, 3'b010, "R3 load word off3");
  endtask

  task automatic t_unsigned_store();
    t_store(32'hD, 3'b100, 32'h0000005A, "R5 unsigned-coded byte");
    t_store(32'hE, 3'b101, 32'h00009C3D, "R5 unsigned-coded half");
    t_store(32'h0, 3'b110, 32'h13579BDF, "R5 unsigned-coded word");
    t_load(32'hC, 3'b010, "R5 readback w3");
    t_load(32'h0, 3'b010, "R5 readback w0");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem_words[i] = '0;
    for (int i = 0; i < 16; i++) ref_bytes[i] = '0;
    t_reset();
    t_fill();
    t_load_sweep();
    t_store_sweep();
    t_misaligned();
    t_unsigned_store();
    t_load_sweep();
    repeat (2) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule